// File: doc/BRIEF.md
# Multiplexed LCD Scan Sequencer

This block drives the row scan of a character LCD with sixteen common lines and eighty segment lines, run at 1/16 duty. The scan is split into sixteen common periods of equal length. In each period the block walks the sixteen character cells of one text line. For each cell it reads the character code from display memory and the matching five-dot pattern row from the glyph tables. It then shifts those eighty dots, one per clock, into a segment shift register. When the period ends, the shift register is copied to the segment outputs and the next common line is selected.

Commons 1 to 8 show pattern rows 0 to 7 of the first text line, and commons 9 to 16 show the second text line. Several features sit on top of the plain pattern. A display shift offset rotates both lines within their own sixteen-address ranges. Display-off blanking clears all segments. A cursor underline draws the eighth pattern row, and a blink block fills the cursor cell. Two orientation bits mirror the segment order and reverse the common order within each half. A frame alternation output lets a downstream driver swap drive polarity on every frame.

Both memory read ports are asynchronous lookups. An address presented in a cycle returns its data in the same cycle.

Top module: `lcd_scan_seq`

## Requirements
- R1: While reset is high, and after reset until the first common period has ended, `com`, `seg` and `frame_alt` are all zero.
- R2: Every COM_CLKS clocks after reset, the segment outputs and the commons update together, and nowhere else. From the first update on, exactly one common is high. Successive updates show logical rows 0,1,...,15 and then repeat.
- R3: Logical rows 0-7 use character addresses 0x00-0x0F and pattern rows 0-7. Logical rows 8-15 use addresses 0x40-0x4F and pattern rows 0-7.
- R4: Character column c (0 = leftmost) shows the address line_base + ((c + shift_ofs) mod 16), on both lines at once.
- R5: Pattern bit 4 is the leftmost dot of a cell. With seg_mirror=0, dot d (0..4) of column c appears on seg[5c+d].
- R6: With seg_mirror=1, dot d of column c appears on seg[79-(5c+d)].
- R7: Logical row r drives com[r] when com_flip=0, and com[8*(r/8) + 7 - (r mod 8)] when com_flip=1. com[0] is common 1.
- R8: When disp_on is low, every segment bit of the row is 0. This holds even if the cursor or blink is enabled.
- R9: With cursor_on=1, pattern row 7 of the cell whose address equals cursor_addr shows all five dots.
- R10: A blink phase starts at 0 and toggles after every BLINK_FRAMES frames. When blink_on=1 and the phase is 1, every pattern row of the cursor cell shows all five dots. When the phase is 0, the cell shows its normal pattern.
- R11: Each row carries a frame index: the number of completed 16-row scans before the period in which that row was shifted. `frame_alt` equals the low bit of the frame index of the row now shown. It changes only at a segment update.

Each row's frame index is its position in the sequence of updates divided by 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_on | input | 1 | Display enable (0 blanks all segments) |
| cursor_on | input | 1 | Cursor underline enable |
| blink_on | input | 1 | Cursor blink enable |
| seg_mirror | input | 1 | Reverse the segment order |
| com_flip | input | 1 | Reverse the common order within each half |
| shift_ofs | input | 4 | Display shift offset, modulo 16 |
| cursor_addr | input | 7 | Character address of the cursor |
| dd_addr | output | 7 | Display memory read address |
| dd_code | input | 8 | Character code at dd_addr (same cycle) |
| pat_code | output | 8 | Glyph lookup character code |
| pat_row | output | 3 | Glyph lookup pattern row |
| pat_bits | input | 5 | Glyph row dots, bit 4 leftmost (same cycle) |
| seg | output | 80 | Latched segment select lines |
| com | output | 16 | Common select lines, one-hot |
| frame_alt | output | 1 | Frame parity for polarity inversion |

## Verification
The assertions assume a few things about the inputs. The read ports return stable data within the cycle, and reset runs long enough for the period counter to start at zero. The blanking check also assumes that disp_on is low for a whole common period before that row's segments appear. The stimulus changes the mode flags, the memory contents and the cursor address only in the half cycle after a segment update, so every row is shifted with one constant set of inputs. The cursor address is drawn from the line being scanned, so the cursor overlays land often. The bench shortens the period and the blink interval so that both blink phases and many frame alternations appear within the run.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

    localparam int DOT_W         = 5;
    localparam int CHARS         = 16;
    localparam int SEG_W         = CHARS * DOT_W;
    localparam int ROWS_PER_LINE = 8;
    localparam int COMMONS       = 2 * ROWS_PER_LINE;
    localparam int ROW_W         = $clog2(COMMONS);
    localparam int CHR_W         = $clog2(CHARS);
    localparam int PROW_W        = $clog2(ROWS_PER_LINE);
    localparam int ADDR_W        = 7;
    localparam int CODE_W        = 8;
    localparam logic [ADDR_W-1:0] LINE2_BASE = 7'h40;

    typedef logic [ROW_W-1:0] row_t;

    typedef struct packed {
        logic disp_on;
        logic cursor_on;
        logic blink_on;
        logic seg_mirror;
        logic com_flip;
    } view_mode_t;

    typedef struct packed {
        logic             shift_en;
        logic             latch_en;
        row_t             row;
        logic [CHR_W-1:0] chr;
        logic [2:0]       dot;
    } scan_pos_t;

    function automatic logic [COMMONS-1:0] common_select(row_t r, logic flip);
        row_t idx;
        idx = flip ? {r[ROW_W-1], ~r[PROW_W-1:0]} : r;
        return COMMONS'(1) << idx;
    endfunction

    function automatic logic [ADDR_W-1:0] cell_addr(row_t r, logic [CHR_W-1:0] chr,
                                                    logic [CHR_W-1:0] ofs);
        logic [CHR_W-1:0] col;
        col = chr + ofs;
        return (r[ROW_W-1] ? LINE2_BASE : '0) | ADDR_W'(col);
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcdscan_pkg::*;
#(
    parameter int COM_CLKS     = 160,
    parameter int BLINK_FRAMES = 32
) (
    input  logic      clk,
    input  logic      rst,
    output scan_pos_t pos,
    output logic      blink_phase,
    output logic      frame_alt
);
    localparam int CNT_W = $clog2(COM_CLKS);
    localparam int BF_W  = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

    logic [CNT_W-1:0] cnt;
    logic [BF_W-1:0]  bcnt;
    logic             fr_par;
    row_t             row;
    logic [CHR_W-1:0] chr;
    logic [2:0]       dot;
    logic             shift_en, latch_en, wrap;

    assign shift_en = cnt < CNT_W'(SEG_W);
    assign latch_en = cnt == CNT_W'(COM_CLKS - 1);
    assign wrap     = latch_en && (row == row_t'(COMMONS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            row <= '0;
            chr <= '0;
            dot <= '0;
        end else begin
            cnt <= latch_en ? '0 : cnt + 1'b1;
            if (latch_en) begin
                row <= row + 1'b1;
                chr <= '0;
                dot <= '0;
            end else if (shift_en) begin
                if (dot == 3'(DOT_W - 1)) begin
                    dot <= '0;
                    chr <= chr + 1'b1;
                end else begin
                    dot <= dot + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_par      <= 1'b0;
            bcnt        <= '0;
            blink_phase <= 1'b0;
            frame_alt   <= 1'b0;
        end else begin
            if (latch_en) frame_alt <= fr_par;
            if (wrap) begin
                fr_par <= ~fr_par;
                if (bcnt == BF_W'(BLINK_FRAMES - 1)) begin
                    bcnt        <= '0;
                    blink_phase <= ~blink_phase;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    assign pos = '{shift_en: shift_en, latch_en: latch_en, row: row, chr: chr, dot: dot};

endmodule

// File: rtl/lcd_dot_fetch.sv
module lcd_dot_fetch
    import lcdscan_pkg::*;
(
    input  scan_pos_t          pos,
    input  view_mode_t         mode,
    input  logic               blink_phase,
    input  logic [CHR_W-1:0]   shift_ofs,
    input  logic [ADDR_W-1:0]  cursor_addr,
    input  logic [CODE_W-1:0]  dd_code,
    input  logic [DOT_W-1:0]   pat_bits,
    output logic [ADDR_W-1:0]  dd_addr,
    output logic [CODE_W-1:0]  pat_code,
    output logic [PROW_W-1:0]  pat_row,
    output logic               dot_bit
);
    logic             at_cursor, solid;
    logic [DOT_W-1:0] row_bits;
    logic [2:0]       bit_sel;

    always_comb begin
        dd_addr   = cell_addr(pos.row, pos.chr, shift_ofs);
        pat_code  = dd_code;
        pat_row   = pos.row[PROW_W-1:0];
        at_cursor = dd_addr == cursor_addr;
        solid     = at_cursor && ((mode.blink_on && blink_phase) ||
                                  (mode.cursor_on && pat_row == PROW_W'(ROWS_PER_LINE - 1)));
        if (!mode.disp_on)
            row_bits = '0;
        else if (solid)
            row_bits = '1;
        else
            row_bits = pat_bits;
        bit_sel = 3'(DOT_W - 1) - pos.dot;
        dot_bit = row_bits[bit_sel];
    end

endmodule

// File: rtl/lcd_seg_shifter.sv
module lcd_seg_shifter
    import lcdscan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  scan_pos_t          pos,
    input  view_mode_t         mode,
    input  logic               dot_bit,
    output logic [SEG_W-1:0]   seg,
    output logic [COMMONS-1:0] com
);
    logic [SEG_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            seg  <= '0;
            com  <= '0;
        end else begin
            if (pos.shift_en) begin
                if (mode.seg_mirror)
                    sreg <= {sreg[SEG_W-2:0], dot_bit};
                else
                    sreg <= {dot_bit, sreg[SEG_W-1:1]};
            end
            if (pos.latch_en) begin
                seg <= sreg;
                com <= common_select(pos.row, mode.com_flip);
            end
        end
    end

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcdscan_pkg::*;
#(
    parameter int COM_CLKS     = 160,
    parameter int BLINK_FRAMES = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         disp_on,
    input  logic         cursor_on,
    input  logic         blink_on,
    input  logic         seg_mirror,
    input  logic         com_flip,
    input  logic [3:0]   shift_ofs,
    input  logic [6:0]   cursor_addr,
    output logic [6:0]   dd_addr,
    input  logic [7:0]   dd_code,
    output logic [7:0]   pat_code,
    output logic [2:0]   pat_row,
    input  logic [4:0]   pat_bits,
    output logic [79:0]  seg,
    output logic [15:0]  com,
    output logic         frame_alt
);
    scan_pos_t  pos;
    view_mode_t mode;
    logic       blink_phase;
    logic       dot_bit;

    assign mode = '{disp_on: disp_on, cursor_on: cursor_on, blink_on: blink_on,
                    seg_mirror: seg_mirror, com_flip: com_flip};

    lcd_scan_timer #(.COM_CLKS(COM_CLKS), .BLINK_FRAMES(BLINK_FRAMES)) u_timer (
        .clk(clk), .rst(rst), .pos(pos), .blink_phase(blink_phase), .frame_alt(frame_alt)
    );

    lcd_dot_fetch u_fetch (
        .pos(pos), .mode(mode), .blink_phase(blink_phase), .shift_ofs(shift_ofs),
        .cursor_addr(cursor_addr), .dd_code(dd_code), .pat_bits(pat_bits),
        .dd_addr(dd_addr), .pat_code(pat_code), .pat_row(pat_row), .dot_bit(dot_bit)
    );

    lcd_seg_shifter u_shift (
        .clk(clk), .rst(rst), .pos(pos), .mode(mode), .dot_bit(dot_bit),
        .seg(seg), .com(com)
    );

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk
    import lcdscan_pkg::*;
#(
    parameter int COM_CLKS = 160
) (
    input logic               clk,
    input logic               rst,
    input logic               disp_on,
    input logic [SEG_W-1:0]   seg,
    input logic [COMMONS-1:0] com,
    input logic               frame_alt
);
    localparam int CNT_W = $clog2(COM_CLKS);

    logic [CNT_W-1:0] ccnt;
    logic             seen, off_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccnt    <= '0;
            seen    <= 1'b0;
            off_run <= 1'b0;
        end else begin
            ccnt    <= (ccnt == CNT_W'(COM_CLKS - 1)) ? '0 : ccnt + 1'b1;
            if (ccnt == CNT_W'(COM_CLKS - 1)) seen <= 1'b1;
            off_run <= (ccnt == '0) ? !disp_on : (off_run && !disp_on);
        end
    end

    AST_IDLE_BEFORE_FIRST: assert property (@(posedge clk) disable iff (rst)
        !seen |-> (com == '0 && seg == '0 && !frame_alt)); // R1
    AST_ONE_COMMON: assert property (@(posedge clk) disable iff (rst)
        seen |-> $onehot(com)); // R2
    AST_COM_STEADY: assert property (@(posedge clk) disable iff (rst)
        (ccnt != '0) |-> ($stable(com) && $stable(seg))); // R2
    AST_PARITY_STEADY: assert property (@(posedge clk) disable iff (rst)
        (ccnt != '0) |-> $stable(frame_alt)); // R11
    AST_DARK_ROW: assert property (@(posedge clk) disable iff (rst)
        (ccnt == '0 && seen && off_run) |-> (seg == '0)); // R8

endmodule

bind lcd_scan_seq lcd_scan_chk #(.COM_CLKS(COM_CLKS)) u_chk (
    .clk(clk), .rst(rst), .disp_on(disp_on), .seg(seg), .com(com), .frame_alt(frame_alt)
);

// File: tb/sim_lcd_scan_seq.sv
module sim_lcd_scan_seq;
    localparam int P     = 90;
    localparam int BF    = 4;
    localparam int NROWS = 160;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_on = 1'b1, cursor_on = 1'b0, blink_on = 1'b0;
    logic        seg_mirror = 1'b0, com_flip = 1'b0;
    logic [3:0]  shift_ofs = '0;
    logic [6:0]  cursor_addr = '0;
    logic [6:0]  dd_addr;
    logic [7:0]  dd_code;
    logic [7:0]  pat_code;
    logic [2:0]  pat_row;
    logic [4:0]  pat_bits;
    logic [79:0] seg;
    logic [15:0] com;
    logic        frame_alt;
    logic [7:0]  salt = 8'h00;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lcd_scan_seq #(.COM_CLKS(P), .BLINK_FRAMES(BF)) u0 (
        .clk(clk), .rst(rst), .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
        .seg_mirror(seg_mirror), .com_flip(com_flip), .shift_ofs(shift_ofs),
        .cursor_addr(cursor_addr), .dd_addr(dd_addr), .dd_code(dd_code),
        .pat_code(pat_code), .pat_row(pat_row), .pat_bits(pat_bits),
        .seg(seg), .com(com), .frame_alt(frame_alt)
    );

    function automatic logic [7:0] mem_code(logic [6:0] a, logic [7:0] s);
        logic [7:0] t;
        t = 8'({1'b0, a} * 8'd29);
        return t ^ s;
    endfunction

    function automatic logic [4:0] glyph(logic [7:0] c, logic [2:0] r, logic [7:0] s);
        logic [7:0] t;
        t = (c + 8'({5'b0, r} * 8'd13)) ^ s;
        return t[4:0] ^ t[7:3];
    endfunction

    always_comb dd_code  = mem_code(dd_addr, salt);
    always_comb pat_bits = glyph(pat_code, pat_row, salt);

    function automatic logic [79:0] exp_seg(int n);
        logic [79:0] e;
        int r, f;
        bit ph, line;
        logic [2:0] prow;
        e    = '0;
        r    = n % 16;
        f    = n / 16;
        ph   = ((f / BF) % 2) == 1;
        line = r >= 8;
        prow = 3'(r % 8);
        for (int c = 0; c < 16; c++) begin
            logic [6:0] a;
            logic [4:0] b;
            a = (line ? 7'h40 : 7'h00) | 7'((c + int'(shift_ofs)) % 16);
            b = glyph(mem_code(a, salt), prow, salt);
            if (a == cursor_addr && ((blink_on && ph) || (cursor_on && prow == 3'd7))) b = 5'h1f;
            if (!disp_on) b = 5'h00;
            for (int d = 0; d < 5; d++) begin
                int k;
                k = c * 5 + d;
                e[seg_mirror ? 79 - k : k] = b[4 - d];
            end
        end
        return e;
    endfunction

    function automatic logic [15:0] exp_com(int n);
        int r, idx;
        r   = n % 16;
        idx = com_flip ? (r / 8) * 8 + 7 - (r % 8) : r;
        return 16'(1) << idx;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic set_inputs(int n);
        int f;
        f = n / 16;
        salt = 8'($urandom);
        case (f)
            0: begin disp_on = 1; cursor_on = 0; blink_on = 0; seg_mirror = 0; com_flip = 0;
                     shift_ofs = 0; cursor_addr = 7'h7f; end
            1: begin disp_on = 1; cursor_on = 1; blink_on = 1; seg_mirror = 0; com_flip = 0;
                     shift_ofs = 4'd5; cursor_addr = 7'h42; end
            2: begin disp_on = 1; cursor_on = 1; blink_on = 0; seg_mirror = 1; com_flip = 1;
                     shift_ofs = 4'd15; cursor_addr = 7'h0f; end
            3: begin disp_on = 0; cursor_on = 1; blink_on = 1; seg_mirror = 0; com_flip = 0;
                     shift_ofs = 4'd3; cursor_addr = ((n % 16) >= 8) ? 7'h44 : 7'h04; end
            default: begin
                disp_on    = ($urandom % 5) != 0;
                cursor_on  = 1'($urandom);
                blink_on   = 1'($urandom);
                seg_mirror = 1'($urandom);
                com_flip   = 1'($urandom);
                shift_ofs  = 4'($urandom);
                cursor_addr = {((n % 16) >= 8), 2'b00, 4'($urandom)};
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(seg == '0, "R1", "seg in reset", seg, '0);
        check(com == '0, "R1", "com in reset", 80'(com), '0);
        check(frame_alt == 1'b0, "R1", "frame_alt in reset", 80'(frame_alt), '0);
        set_inputs(0);
        rst = 1'b0;
        for (int n = 0; n < NROWS; n++) begin
            logic [79:0] es;
            logic [15:0] ec;
            string tag;
            int f;
            bit ph;
            if (n == 0) begin
                repeat (P - 1) @(posedge clk);
                @(negedge clk);
                check(com == '0 && seg == '0, "R1", "outputs before first update",
                      {com, seg[63:0]}, '0);
                @(posedge clk);
            end else begin
                repeat (P) @(posedge clk);
            end
            @(negedge clk);
            f  = n / 16;
            ph = ((f / BF) % 2) == 1;
            es = exp_seg(n);
            ec = exp_com(n);
            if (!disp_on)                      tag = "R8";
            else if (blink_on)                 tag = ph ? "R10 phase1" : "R10 phase0";
            else if (cursor_on && (n % 8) == 7) tag = "R9";
            else if (seg_mirror)               tag = "R6";
            else if (shift_ofs != 0)           tag = "R4";
            else if ((n % 16) >= 8)            tag = "R3";
            else                               tag = "R5";
            check(seg == es, tag, $sformatf("seg row %0d", n), seg, es);
            check(com == ec, com_flip ? "R7" : "R2", $sformatf("com row %0d", n),
                  80'(com), 80'(ec));
            check(frame_alt == 1'(f), "R11", $sformatf("frame_alt row %0d", n),
                  80'(frame_alt), 80'(1'(f)));
            if (n + 1 < NROWS) set_inputs(n + 1);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule